// File: doc/BRIEF.md
# Differential QPSK Phase Encoder

This block sits in a burst transmitter ahead of pulse shaping. It takes a stream of 2-bit symbols (dibits) and turns each one into an absolute carrier phase. A stored quadrant index is advanced by the rotation that each accepted dibit selects. The new phase leaves the block one cycle later, both as a 2-bit quadrant index and as a pair of I/Q sign bits.

A static mode input picks between two rotation conventions. In the inverted convention the quarter-turn directions for dibits 01 and 10 are swapped. This lets the transmitter pre-compensate a receiver that demodulates a mirrored spectral image of the IF. Without that swap, the receiver would decode those symbols wrongly. Each burst begins by forcing the phase back to quadrant 0. The mode is captured at that same point, so that one burst never mixes the two conventions.

Top module: `dqpsk_phase_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets synchronously. After that edge `outQuad` is 0, `outValid` is 0, and both sign outputs are 0.
- R2: An accepted dibit 2'b00 leaves the quadrant unchanged in both modes.
- R3: An accepted dibit 2'b11 adds 2 to the quadrant, modulo 4 (a 180 degree turn), in both modes.
- R4: In normal mode (effective mode 0), dibit 2'b01 subtracts 1 from the quadrant (-90 degrees) and dibit 2'b10 adds 1 (+90 degrees), modulo 4.
- R5: In inverted mode (effective mode 1), dibit 2'b01 adds 1 to the quadrant and dibit 2'b10 subtracts 1, modulo 4.
- R6: A dibit is accepted on a clock edge where `inValid` is high. The new quadrant and `outValid` = 1 appear right after that edge. On an edge with `inValid` low, `outValid` goes to 0, and the quadrant holds unless `burstStart` is high.
- R7: On an edge with `burstStart` high, the phase is set to quadrant 0 before any dibit accepted on that same edge is applied. The output after that edge is therefore the rotation of that dibit from 0, or 0 if no dibit was accepted.
- R8: Quadrant index q stands for q*90 degrees. Sign bits are 1 for negative: quadrant 0 gives I=0,Q=0; quadrant 1 gives I=1,Q=0; quadrant 2 gives I=1,Q=1; quadrant 3 gives I=0,Q=1.
- R9: From reset until the first `burstStart`, the effective mode follows `invertMode` on every edge. On each `burstStart` edge the effective mode is taken from `invertMode` and then held. Changes to `invertMode` after that are ignored until the next `burstStart`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| invertMode | input | 1 | Rotation convention: 0 normal, 1 inverted |
| burstStart | input | 1 | Returns phase to 0 and captures the mode |
| inValid | input | 1 | Dibit on `inDibit` is accepted this edge |
| inDibit | input | 2 | Input symbol |
| outValid | output | 1 | A new phase was produced on the last edge |
| outQuad | output | 2 | Current quadrant index (q * 90 degrees) |
| outISign | output | 1 | In-phase sign, 1 = negative |
| outQSign | output | 1 | Quadrature sign, 1 = negative |

## Verification
The bench targets the swapped quarter-turns. A design that ignores the mode, or swaps the wrong pair of dibits, drifts away from the degree-accumulating model after the first 01 or 10, and long alternating 01/10 runs make that drift visible. Long runs of 11 catch a wrong 180 degree step or a wrong modulo wrap, because such an error shows up as an odd quadrant on every second symbol. A mode flip in the middle of a burst catches a design that samples the mode on every edge. A burst start coinciding with a valid dibit catches a design that applies the rotation before the clear, or drops the dibit.

// File: rtl/encoder_pkg.sv
package encoder_pkg;
  localparam int SYM_W   = 2;
  localparam int PHASE_W = 2;
  localparam int QUARTER = 1;
  localparam int HALF    = 1 << (PHASE_W - 1);

  typedef logic [PHASE_W-1:0] quad_t;
  typedef logic [SYM_W-1:0]   dibit_t;

  typedef enum logic [SYM_W-1:0] {
    SYM_KEEP  = 2'b00,
    SYM_TURNA = 2'b01,
    SYM_TURNB = 2'b10,
    SYM_FLIP  = 2'b11
  } sym_e;

  typedef struct packed {
    logic advance;
    logic clearPhase;
    logic invert;
  } encStrobe_t;

  // Quadrant increment for one dibit under the selected convention.
  function automatic quad_t rotationStep(input dibit_t d, input logic inv);
    quad_t plusQ;
    quad_t minusQ;
    plusQ  = quad_t'(QUARTER);
    minusQ = quad_t'(-QUARTER);
    case (sym_e'(d))
      SYM_KEEP:  rotationStep = '0;
      SYM_TURNA: rotationStep = inv ? plusQ : minusQ;
      SYM_TURNB: rotationStep = inv ? minusQ : plusQ;
      default:   rotationStep = quad_t'(HALF);
    endcase
  endfunction
endpackage

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import encoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       invertMode,
  input  logic       burstStart,
  input  logic       inValid,
  output encStrobe_t strobe
);
  logic burstActive;
  logic modeHeld;
  logic modeOpen;

  assign modeOpen = burstStart || !burstActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      burstActive <= 1'b0;
      modeHeld    <= 1'b0;
    end else begin
      if (burstStart) burstActive <= 1'b1;
      if (modeOpen)   modeHeld    <= invertMode;
    end
  end

  always_comb begin
    strobe.advance    = inValid;
    strobe.clearPhase = burstStart;
    strobe.invert     = modeOpen ? invertMode : modeHeld;
  end
endmodule

// File: rtl/enc_datapath.sv
module enc_datapath
  import encoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  encStrobe_t strobe,
  input  dibit_t     inDibit,
  output logic       outValid,
  output quad_t      outQuad,
  output logic       outISign,
  output logic       outQSign
);
  quad_t quadReg;
  quad_t basePhase;
  quad_t nextPhase;
  logic  validReg;

  always_comb begin
    basePhase = strobe.clearPhase ? '0 : quadReg;
    nextPhase = strobe.advance ? quad_t'(basePhase + rotationStep(inDibit, strobe.invert))
                               : basePhase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quadReg  <= '0;
      validReg <= 1'b0;
    end else begin
      quadReg  <= nextPhase;
      validReg <= strobe.advance;
    end
  end

  always_comb begin
    case (quadReg)
      2'd0:    {outISign, outQSign} = 2'b00;
      2'd1:    {outISign, outQSign} = 2'b10;
      2'd2:    {outISign, outQSign} = 2'b11;
      default: {outISign, outQSign} = 2'b01;
    endcase
  end

  assign outQuad  = quadReg;
  assign outValid = validReg;
endmodule

// File: rtl/dqpsk_phase_encoder.sv
module dqpsk_phase_encoder
  import encoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       invertMode,
  input  logic       burstStart,
  input  logic       inValid,
  input  logic [1:0] inDibit,
  output logic       outValid,
  output logic [1:0] outQuad,
  output logic       outISign,
  output logic       outQSign
);
  encStrobe_t strobe;

  enc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .invertMode (invertMode),
    .burstStart (burstStart),
    .inValid    (inValid),
    .strobe     (strobe)
  );

  enc_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inDibit  (inDibit),
    .outValid (outValid),
    .outQuad  (outQuad),
    .outISign (outISign),
    .outQSign (outQSign)
  );
endmodule

// File: rtl/enc_checker.sv
module enc_checker (
  input logic       clk,
  input logic       rst,
  input logic       burstStart,
  input logic       inValid,
  input logic [1:0] inDibit,
  input logic       outValid,
  input logic [1:0] outQuad,
  input logic       outISign,
  input logic       outQSign
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outQuad == 2'd0 && !outValid && !outISign && !outQSign)); // R1
  AST_KEEP_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid) && !$past(burstStart) && $past(inDibit) == 2'b00)
      |-> $stable(outQuad)); // R2
  AST_FLIP_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid) && !$past(burstStart) && $past(inDibit) == 2'b11)
      |-> (outQuad == 2'($past(outQuad) + 2'd2))); // R3
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(inValid))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid) && !$past(burstStart)) |-> $stable(outQuad)); // R6
  AST_BURST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(burstStart) && !$past(inValid)) |-> (outQuad == 2'd0)); // R7
  AST_SIGN_PARITY: assert property (@(posedge clk) disable iff (rst)
    (outISign ^ outQSign) == outQuad[0]); // R8
endmodule

bind dqpsk_phase_encoder enc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .burstStart (burstStart),
  .inValid    (inValid),
  .inDibit    (inDibit),
  .outValid   (outValid),
  .outQuad    (outQuad),
  .outISign   (outISign),
  .outQSign   (outQSign)
);

// File: tb/test_dqpsk_phase_encoder.sv
module test_dqpsk_phase_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // Vector fields: {burstStart, invertMode, inValid, inDibit[1:0]}
  localparam logic [4:0] VECS [NVEC] = '{
    5'b1_0_1_01, 5'b0_0_1_10, 5'b0_0_1_10, 5'b0_0_1_11,
    5'b0_0_1_00, 5'b0_0_1_01, 5'b0_0_0_11, 5'b0_0_1_11,
    5'b1_1_1_01, 5'b0_1_1_01, 5'b0_1_1_10, 5'b0_1_1_00,
    5'b0_1_1_11, 5'b0_1_1_01, 5'b1_0_0_00, 5'b0_0_1_10,
    5'b1_1_1_10, 5'b0_1_1_10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic invertMode = 1'b0;
  logic burstStart = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inDibit = 2'b00;
  logic outValid;
  logic [1:0] outQuad;
  logic outISign;
  logic outQSign;

  int checks = 0;
  int errors = 0;
  int refDeg = 0;
  bit refMode = 1'b0;
  bit refActive = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqpsk_phase_encoder i_dqpsk_phase_encoder (
    .clk(clk), .rst(rst), .invertMode(invertMode), .burstStart(burstStart),
    .inValid(inValid), .inDibit(inDibit), .outValid(outValid), .outQuad(outQuad),
    .outISign(outISign), .outQSign(outQSign)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rotDeg(input logic [1:0] d, input bit inv);
    case (d)
      2'b00:   return 0;
      2'b11:   return 180;
      2'b01:   return inv ? 90 : -90;
      default: return inv ? -90 : 90;
    endcase
  endfunction

  function automatic string tagFor(input logic [1:0] d, input bit inv, input bit bs);
    if (bs) return "R7";
    if (d == 2'b00) return "R2";
    if (d == 2'b11) return "R3";
    return inv ? "R5" : "R4";
  endfunction

  // Apply one cycle of stimulus, update the degree model, then check after the edge.
  task automatic step(input bit bs, input bit mode, input bit v, input logic [1:0] d,
                      input string req);
    bit effMode;
    int norm;
    @(negedge clk);
    burstStart = bs; invertMode = mode; inValid = v; inDibit = d;
    effMode = (bs || !refActive) ? mode : refMode;
    if (bs) begin refDeg = 0; refActive = 1'b1; end
    if (bs || !refActive) refMode = mode;
    if (v) refDeg += rotDeg(d, effMode);
    @(posedge clk); #1;
    norm = ((refDeg % 360) + 360) % 360;
    chk(req, outQuad, norm / 90);
    chk({req, " valid R6"}, outValid, v);
    chk({req, " isign R8"}, outISign, (norm == 90 || norm == 180) ? 1 : 0);
    chk({req, " qsign R8"}, outQSign, (norm == 180 || norm == 270) ? 1 : 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; burstStart = 1'b0; inValid = 1'b0;
    @(posedge clk); #1;
    refDeg = 0; refActive = 1'b0; refMode = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // r1_ reset state
    inValid = 1'b1; inDibit = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 quad", outQuad, 0);
    chk("R1 valid", outValid, 0);
    chk("R1 isign", outISign, 0);
    chk("R1 qsign", outQSign, 0);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][4], VECS[i][3], VECS[i][2], VECS[i][1:0],
           tagFor(VECS[i][1:0], VECS[i][3], VECS[i][4]));
    end

    // Long run of 11 in both modes (R3)
    step(1'b1, 1'b0, 1'b1, 2'b01, "R7");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1, 2'b11, "R3");
    step(1'b1, 1'b1, 1'b1, 2'b10, "R7");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, 2'b11, "R3");

    // Alternating 01/10 runs, each mode, with a single extra turn first
    step(1'b1, 1'b0, 1'b1, 2'b10, "R7");
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b1, (i % 2) ? 2'b10 : 2'b01, "R4");
    step(1'b1, 1'b1, 1'b1, 2'b10, "R7");
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b1, (i % 2) ? 2'b10 : 2'b01, "R5");

    // Repeated same-direction turns wrap around the circle
    step(1'b1, 1'b0, 1'b0, 2'b00, "R7");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b1, 2'b01, "R4");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b1, 2'b10, "R4");

    // Mid-burst mode change ignored (R9): burst in normal, then input says inverted
    step(1'b1, 1'b0, 1'b1, 2'b10, "R9 start");
    step(1'b0, 1'b1, 1'b1, 2'b10, "R9 mid-burst flip");
    step(1'b0, 1'b1, 1'b1, 2'b01, "R9 mid-burst flip");
    // Hold with no valid and no burst start (R6)
    step(1'b0, 1'b1, 1'b0, 2'b11, "R6 hold");
    step(1'b0, 1'b0, 1'b0, 2'b10, "R6 hold");
    // Next burst picks up the new mode
    step(1'b1, 1'b1, 1'b1, 2'b01, "R9 new burst");
    step(1'b0, 1'b0, 1'b1, 2'b01, "R9 held inverted");

    // Idle mode tracking after reset (R9): no burst start yet
    doReset();
    chk("R1 after mid-run reset", outQuad, 0);
    step(1'b0, 1'b1, 1'b1, 2'b01, "R9 idle inverted");
    step(1'b0, 1'b0, 1'b1, 2'b01, "R9 idle normal");
    step(1'b0, 1'b1, 1'b1, 2'b10, "R9 idle inverted");

    // Burst start without a symbol clears to quadrant 0 (R7)
    step(1'b0, 1'b1, 1'b1, 2'b11, "R3");
    step(1'b1, 1'b1, 1'b0, 2'b11, "R7 clear only");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule